// File: doc/BRIEF.md
# Tag-Renaming Reservation Station Cluster

This block accepts operations one at a time, in program order, and runs them out of order. Each operation names an opcode, a destination register, up to two source registers and an immediate. It is placed in a small reservation station of its class: add/subtract, multiply/divide, or load. At placement the block resolves each source. If no producer is pending for that register, the station takes the register's value. If a producer is pending, the station takes that producer's station tag. A register status table records, for each register, the tag of the newest pending producer. This renames registers at issue, so later writers never wait for earlier readers or earlier writers.

Every station owns a fixed-latency execution unit. A station starts only once both of its operands hold values. A single shared result bus carries one tag and value per cycle. Every waiting station and the register file snoop this bus. When several results are ready together, the lowest tag goes first and the others hold. A load station computes its address from its base operand plus the immediate and reads the value from an external memory port.

Top module: `rs_core`

## Requirements
- R1: After reset all registers read 0, no register has a pending producer, the bus is idle, no memory read is requested, and `iss_ready` is high for a valid opcode.
- R2: Opcode encoding: 0 adds, 1 subtracts (src1 − src2), 2 multiplies (low XLEN bits), 3 divides (src1 / src2, all ones when the divisor is 0), 4 loads. Codes 5 to 7 are never accepted: `iss_ready` stays low for them.
- R3: An operation issues only when a station of its class is free. Classes are add/sub, mul/div and load. Otherwise `iss_ready` is low, and holding `iss_valid` high has no effect on any register.
- R4: Stations are numbered add class first, then mul class, then load class. Station k has tag k+1, and the lowest-numbered free station of the class is chosen. Tag 0 means "value present" and never appears on the bus.
- R5: At issue, each source is captured as the register value when no producer is pending, otherwise as the pending producer's tag.
- R6: With both operands present at issue and no competing result, the result appears on the bus LAT+1 cycles after the issuing edge. LAT is ADD_LAT for add/sub and MUL_LAT for mul/div.
- R7: At most one result is broadcast per cycle. The lowest tag wins, and any other finished station keeps its result for a later cycle.
- R8: A broadcast writes a register only when that register's status still holds the broadcast tag, and then clears the status. An older producer never overwrites the result of a newer writer.
- R9: A later writer may complete before an earlier reader of the same register has started. The reader still computes with the value it was renamed to.
- R10: When an issue reads a register whose producer broadcasts in the same cycle, the new station captures the broadcast value and does not wait.
- R11: A load asserts `ld_req` with `ld_addr` = base register + immediate in its final execute cycle, and takes `ld_data` in that same cycle. The lowest-tag requesting load station owns the port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Operation offered for issue |
| iss_op | input | 3 | Opcode |
| iss_dst | input | log2(NREG) | Destination register |
| iss_src1 | input | log2(NREG) | First source / load base register |
| iss_src2 | input | log2(NREG) | Second source register |
| iss_imm | input | XLEN | Load address offset |
| iss_ready | output | 1 | A station of the offered opcode's class is free |
| bus_valid | output | 1 | Result bus carries a result |
| bus_tag | output | log2(NS+1) | Tag of the producing station |
| bus_value | output | XLEN | Broadcast result value |
| ld_req | output | 1 | Memory read in this cycle |
| ld_addr | output | XLEN | Memory read address |
| ld_data | input | XLEN | Memory read data, same cycle |
| rd_idx | input | log2(NREG) | Register file observation index |
| rd_value | output | XLEN | Committed value of register `rd_idx` |

## Verification
Two things can fall in the same cycle: a result broadcast and the issue of an operation that names the broadcasting station's destination as a source. The bench provokes this by watching the bus at the falling edge. When the expected tag appears, it offers the dependent operation at once, so issue and broadcast share the next rising edge. The dependent result is then compared with the sum the bench computes; a lost wakeup would leave the station waiting forever. Two stations finishing in the same cycle are also forced by issue spacing, and the bench judges the order and values on the bus over the two following cycles.

// File: rtl/rs_pkg.sv
package rs_pkg;

    localparam int DEF_XLEN    = 16;
    localparam int DEF_NREG    = 8;
    localparam int DEF_N_ADD   = 2;
    localparam int DEF_N_MUL   = 2;
    localparam int DEF_N_LD    = 1;
    localparam int DEF_ADD_LAT = 2;
    localparam int DEF_MUL_LAT = 4;
    localparam int DEF_LD_LAT  = 1;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_MUL = 3'd2,
        OP_DIV = 3'd3,
        OP_LD  = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        CL_ADD  = 2'd0,
        CL_MUL  = 2'd1,
        CL_LD   = 2'd2,
        CL_NONE = 2'd3
    } cls_e;

    typedef enum logic [1:0] {
        S_FREE = 2'd0,
        S_WAIT = 2'd1,
        S_EXEC = 2'd2,
        S_DONE = 2'd3
    } st_e;

    function automatic cls_e op_class(input logic [2:0] op);
        case (op)
            3'd0, 3'd1: return CL_ADD;
            3'd2, 3'd3: return CL_MUL;
            3'd4:       return CL_LD;
            default:    return CL_NONE;
        endcase
    endfunction

    function automatic cls_e station_class(input int s, input int n_add, input int n_mul);
        if (s < n_add)         return CL_ADD;
        if (s < n_add + n_mul) return CL_MUL;
        return CL_LD;
    endfunction

endpackage

// File: rtl/rs_arb.sv
module rs_arb #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    // lowest set bit wins
    assign gnt = req & (~req + N'(1));
endmodule

// File: rtl/rs_station.sv
module rs_station
    import rs_pkg::*;
#(
    parameter int XLEN = 16,
    parameter int TW   = 3,
    parameter int LAT  = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            alloc,
    input  op_e             a_op,
    input  logic [XLEN-1:0] a_vj,
    input  logic [XLEN-1:0] a_vk,
    input  logic [TW-1:0]   a_qj,
    input  logic [TW-1:0]   a_qk,
    input  logic [XLEN-1:0] a_imm,
    input  logic            bus_valid,
    input  logic [TW-1:0]   bus_tag,
    input  logic [XLEN-1:0] bus_value,
    input  logic            grant,
    input  logic            mem_gnt,
    input  logic [XLEN-1:0] mem_rdata,
    output logic            busy,
    output logic            req,
    output logic [XLEN-1:0] res,
    output logic            mem_req,
    output logic [XLEN-1:0] mem_addr
);
    localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

    st_e             st;
    op_e             op;
    logic [XLEN-1:0] vj, vk, imm, res_q, alu;
    logic [TW-1:0]   qj, qk;
    logic [CW-1:0]   cnt;
    logic            hit_j, hit_k;

    assign hit_j = (qj != '0) && bus_valid && (bus_tag == qj);
    assign hit_k = (qk != '0) && bus_valid && (bus_tag == qk);

    always_comb begin
        case (op)
            OP_ADD:  alu = vj + vk;
            OP_SUB:  alu = vj - vk;
            OP_MUL:  alu = vj * vk;
            OP_DIV:  alu = (vk == '0) ? '1 : vj / vk;
            OP_LD:   alu = mem_rdata;
            default: alu = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= S_FREE;
            op    <= OP_ADD;
            vj    <= '0;
            vk    <= '0;
            imm   <= '0;
            qj    <= '0;
            qk    <= '0;
            cnt   <= '0;
            res_q <= '0;
        end else begin
            case (st)
                S_FREE: if (alloc) begin
                    st  <= S_WAIT;
                    op  <= a_op;
                    vj  <= a_vj;
                    vk  <= a_vk;
                    qj  <= a_qj;
                    qk  <= a_qk;
                    imm <= a_imm;
                end
                S_WAIT: begin
                    if (qj == '0 && qk == '0) begin
                        st  <= S_EXEC;
                        cnt <= CW'(LAT - 1);
                    end
                    if (hit_j) begin
                        vj <= bus_value;
                        qj <= '0;
                    end
                    if (hit_k) begin
                        vk <= bus_value;
                        qk <= '0;
                    end
                end
                S_EXEC: begin
                    if (cnt != '0) begin
                        cnt <= cnt - CW'(1);
                    end else if (op != OP_LD || mem_gnt) begin
                        st    <= S_DONE;
                        res_q <= alu;
                    end
                end
                S_DONE: if (grant) st <= S_FREE;
                default: st <= S_FREE;
            endcase
        end
    end

    assign busy     = (st != S_FREE);
    assign req      = (st == S_DONE);
    assign res      = res_q;
    assign mem_req  = (st == S_EXEC) && (cnt == '0) && (op == OP_LD);
    assign mem_addr = vj + imm;

endmodule

// File: rtl/rs_regstat.sv
module rs_regstat #(
    parameter int XLEN = 16,
    parameter int NREG = 8,
    parameter int TW   = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    set_en,
    input  logic [$clog2(NREG)-1:0] set_reg,
    input  logic [TW-1:0]           set_tag,
    input  logic                    bus_valid,
    input  logic [TW-1:0]           bus_tag,
    input  logic [XLEN-1:0]         bus_value,
    input  logic [$clog2(NREG)-1:0] ra,
    input  logic [$clog2(NREG)-1:0] rb,
    input  logic [$clog2(NREG)-1:0] rc,
    output logic [XLEN-1:0]         va,
    output logic [TW-1:0]           qa,
    output logic [XLEN-1:0]         vb,
    output logic [TW-1:0]           qb,
    output logic [XLEN-1:0]         vc
);
    localparam int RW = $clog2(NREG);

    logic [XLEN-1:0] val [NREG];
    logic [TW-1:0]   tag [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < NREG; r++) begin
                val[r] <= '0;
                tag[r] <= '0;
            end
        end else begin
            for (int r = 0; r < NREG; r++) begin
                // commit only when this broadcast is still the newest producer
                if (bus_valid && tag[r] != '0 && tag[r] == bus_tag) begin
                    val[r] <= bus_value;
                    tag[r] <= '0;
                end
                if (set_en && set_reg == RW'(r))
                    tag[r] <= set_tag;
            end
        end
    end

    assign va = val[ra];
    assign qa = tag[ra];
    assign vb = val[rb];
    assign qb = tag[rb];
    assign vc = val[rc];

endmodule

// File: rtl/rs_core.sv
module rs_core
    import rs_pkg::*;
#(
    parameter int XLEN    = DEF_XLEN,
    parameter int NREG    = DEF_NREG,
    parameter int N_ADD   = DEF_N_ADD,
    parameter int N_MUL   = DEF_N_MUL,
    parameter int N_LD    = DEF_N_LD,
    parameter int ADD_LAT = DEF_ADD_LAT,
    parameter int MUL_LAT = DEF_MUL_LAT,
    parameter int LD_LAT  = DEF_LD_LAT,
    localparam int NS     = N_ADD + N_MUL + N_LD,
    localparam int TW     = $clog2(NS + 1),
    localparam int RW     = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            iss_valid,
    input  logic [2:0]      iss_op,
    input  logic [RW-1:0]   iss_dst,
    input  logic [RW-1:0]   iss_src1,
    input  logic [RW-1:0]   iss_src2,
    input  logic [XLEN-1:0] iss_imm,
    output logic            iss_ready,
    output logic            bus_valid,
    output logic [TW-1:0]   bus_tag,
    output logic [XLEN-1:0] bus_value,
    output logic            ld_req,
    output logic [XLEN-1:0] ld_addr,
    input  logic [XLEN-1:0] ld_data,
    input  logic [RW-1:0]   rd_idx,
    output logic [XLEN-1:0] rd_value
);

    function automatic logic [TW-1:0] oh2tag(input logic [NS-1:0] oh);
        logic [TW-1:0] t;
        t = '0;
        for (int i = 0; i < NS; i++)
            if (oh[i]) t = t | TW'(i + 1);
        return t;
    endfunction

    cls_e            iss_cls;
    op_e             a_op;
    logic            fire;
    logic [NS-1:0]   cand, alloc_oh, st_alloc, st_busy, st_req, bus_gnt;
    logic [NS-1:0]   mem_req_v, mem_gnt_v;
    logic [TW-1:0]   new_tag, qa, qb, a_qj, a_qk;
    logic [XLEN-1:0] va, vb, a_vj, a_vk;
    logic [XLEN-1:0] st_res   [NS];
    logic [XLEN-1:0] st_maddr [NS];
    logic            fwd_j, fwd_k, is_ld;

    // ---------------- issue selection ----------------
    assign iss_cls = op_class(iss_op);
    assign a_op    = op_e'(iss_op);
    assign is_ld   = (iss_cls == CL_LD);

    for (genvar s = 0; s < NS; s++) begin : g_cand
        assign cand[s] = !st_busy[s] && (station_class(s, N_ADD, N_MUL) == iss_cls);
    end

    rs_arb #(.N(NS)) u_iss_arb (.req(cand), .gnt(alloc_oh));

    assign iss_ready = |cand;
    assign fire      = iss_valid && iss_ready;
    assign st_alloc  = fire ? alloc_oh : '0;
    assign new_tag   = oh2tag(alloc_oh);

    // ---------------- register file and status ----------------
    rs_regstat #(.XLEN(XLEN), .NREG(NREG), .TW(TW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .set_en    (fire),
        .set_reg   (iss_dst),
        .set_tag   (new_tag),
        .bus_valid (bus_valid),
        .bus_tag   (bus_tag),
        .bus_value (bus_value),
        .ra        (iss_src1),
        .rb        (iss_src2),
        .rc        (rd_idx),
        .va        (va),
        .qa        (qa),
        .vb        (vb),
        .qb        (qb),
        .vc        (rd_value)
    );

    // same-cycle broadcast is taken directly from the bus
    assign fwd_j = (qa != '0) && bus_valid && (bus_tag == qa);
    assign fwd_k = (qb != '0) && bus_valid && (bus_tag == qb);
    assign a_vj  = fwd_j ? bus_value : va;
    assign a_qj  = fwd_j ? '0 : qa;
    assign a_vk  = is_ld ? '0 : (fwd_k ? bus_value : vb);
    assign a_qk  = (is_ld || fwd_k) ? '0 : qb;

    // ---------------- stations ----------------
    for (genvar s = 0; s < NS; s++) begin : g_st
        localparam int SL = (s < N_ADD) ? ADD_LAT :
                            (s < N_ADD + N_MUL) ? MUL_LAT : LD_LAT;
        rs_station #(.XLEN(XLEN), .TW(TW), .LAT(SL)) u_st (
            .clk       (clk),
            .rst       (rst),
            .alloc     (st_alloc[s]),
            .a_op      (a_op),
            .a_vj      (a_vj),
            .a_vk      (a_vk),
            .a_qj      (a_qj),
            .a_qk      (a_qk),
            .a_imm     (iss_imm),
            .bus_valid (bus_valid),
            .bus_tag   (bus_tag),
            .bus_value (bus_value),
            .grant     (bus_gnt[s]),
            .mem_gnt   (mem_gnt_v[s]),
            .mem_rdata (ld_data),
            .busy      (st_busy[s]),
            .req       (st_req[s]),
            .res       (st_res[s]),
            .mem_req   (mem_req_v[s]),
            .mem_addr  (st_maddr[s])
        );
    end

    // ---------------- result bus and memory port ----------------
    rs_arb #(.N(NS)) u_bus_arb (.req(st_req),    .gnt(bus_gnt));
    rs_arb #(.N(NS)) u_mem_arb (.req(mem_req_v), .gnt(mem_gnt_v));

    assign bus_valid = |st_req;
    assign bus_tag   = oh2tag(bus_gnt);
    assign ld_req    = |mem_req_v;

    always_comb begin
        bus_value = '0;
        ld_addr   = '0;
        for (int s = 0; s < NS; s++) begin
            if (bus_gnt[s])   bus_value = bus_value | st_res[s];
            if (mem_gnt_v[s]) ld_addr   = ld_addr   | st_maddr[s];
        end
    end

endmodule

// File: rtl/rs_core_chk.sv
module rs_core_chk #(
    parameter int NS = 5,
    parameter int TW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic [2:0]    iss_op,
    input logic          iss_ready,
    input logic          bus_valid,
    input logic [TW-1:0] bus_tag,
    input logic [NS-1:0] st_req,
    input logic [NS-1:0] bus_gnt,
    input logic [NS-1:0] st_alloc,
    input logic [NS-1:0] st_busy
);

    a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!bus_valid && st_busy == '0));

    a_r2_bad_opcode: assert property (@(posedge clk) disable iff (rst)
        (iss_op > 3'd4) |-> !iss_ready);

    a_r4_tag_range: assert property (@(posedge clk) disable iff (rst)
        bus_valid |-> (bus_tag != '0 && int'(bus_tag) <= NS));

    a_r7_bus_idle: assert property (@(posedge clk) disable iff (rst)
        !bus_valid |-> (st_req == '0));

    for (genvar s = 0; s < NS; s++) begin : g_s
        a_r7_hold_result: assert property (@(posedge clk) disable iff (rst)
            (st_req[s] && !bus_gnt[s]) |=> st_req[s]);

        a_r3_alloc_busy: assert property (@(posedge clk) disable iff (rst)
            st_alloc[s] |=> st_busy[s]);

        a_r3_no_double_alloc: assert property (@(posedge clk) disable iff (rst)
            st_alloc[s] |-> !st_busy[s]);
    end

endmodule

bind rs_core rs_core_chk #(.NS(NS), .TW(TW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .iss_op    (iss_op),
    .iss_ready (iss_ready),
    .bus_valid (bus_valid),
    .bus_tag   (bus_tag),
    .st_req    (st_req),
    .bus_gnt   (bus_gnt),
    .st_alloc  (st_alloc),
    .st_busy   (st_busy)
);

// File: tb/rs_core_tb.sv
`timescale 1ns/1ps
module rs_core_tb;

    localparam int XLEN = 16;
    localparam int RW   = 3;
    localparam int TW   = 3;
    localparam logic [2:0] C_ADD = 3'd0, C_SUB = 3'd1, C_MUL = 3'd2,
                           C_DIV = 3'd3, C_LD  = 3'd4;

    logic            clk = 1'b0;
    logic            rst;
    logic            iss_valid;
    logic [2:0]      iss_op;
    logic [RW-1:0]   iss_dst, iss_src1, iss_src2, rd_idx;
    logic [XLEN-1:0] iss_imm;
    logic            iss_ready, bus_valid, ld_req;
    logic [TW-1:0]   bus_tag;
    logic [XLEN-1:0] bus_value, ld_addr, ld_data, rd_value;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    // memory model: word at address a holds a*7+3
    assign ld_data = ld_addr * 16'd7 + 16'd3;

    rs_core u_dut (
        .clk (clk), .rst (rst),
        .iss_valid (iss_valid), .iss_op (iss_op), .iss_dst (iss_dst),
        .iss_src1 (iss_src1), .iss_src2 (iss_src2), .iss_imm (iss_imm),
        .iss_ready (iss_ready),
        .bus_valid (bus_valid), .bus_tag (bus_tag), .bus_value (bus_value),
        .ld_req (ld_req), .ld_addr (ld_addr), .ld_data (ld_data),
        .rd_idx (rd_idx), .rd_value (rd_value)
    );

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic chkreg(input string rq, input int idx, input logic [XLEN-1:0] exp);
        rd_idx = RW'(idx);
        #1;
        chk(rq, $sformatf("r%0d", idx), 32'(rd_value), 32'(exp));
    endtask

    // drive at a falling edge; returns at the falling edge after the issuing edge
    task automatic issue(input logic [2:0] op, input int d, input int a, input int b,
                         input logic [XLEN-1:0] imm);
        iss_op    = op;
        iss_dst   = RW'(d);
        iss_src1  = RW'(a);
        iss_src2  = RW'(b);
        iss_imm   = imm;
        iss_valid = 1'b1;
        #1;
        while (!iss_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        iss_valid = 1'b0;
    endtask

    task automatic drain(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk("R1", "bus_valid", 32'(bus_valid), 0);
        chk("R1", "ld_req", 32'(ld_req), 0);
        iss_op = C_ADD; #1;
        chk("R1", "ready add", 32'(iss_ready), 1);
        for (int r = 0; r < 8; r++) chkreg("R1", r, 16'h0);
        iss_op = 3'd5; #1;
        chk("R2", "ready op5", 32'(iss_ready), 0);
        iss_op = 3'd7; #1;
        chk("R2", "ready op7", 32'(iss_ready), 0);
        iss_op = C_ADD;
    endtask

    task automatic t_ops();
        issue(C_LD, 1, 0, 0, 16'd5);     // r1 = 38
        issue(C_LD, 2, 0, 0, 16'd9);     // r2 = 66, waits for the single load station
        issue(C_ADD, 3, 1, 2, 16'd0);
        issue(C_SUB, 4, 1, 2, 16'd0);
        issue(C_MUL, 5, 1, 2, 16'd0);
        issue(C_DIV, 6, 2, 1, 16'd0);
        issue(C_DIV, 7, 1, 0, 16'd0);
        drain(30);
        chkreg("R11", 1, 16'd38);
        chkreg("R11", 2, 16'd66);
        chkreg("R2", 3, 16'd104);
        chkreg("R2", 4, 16'hFFE4);
        chkreg("R2", 5, 16'd2508);
        chkreg("R2", 6, 16'd1);
        chkreg("R2", 7, 16'hFFFF);
        issue(C_LD, 6, 1, 0, 16'd2);     // address 40 -> 283
        chk("R11", "ld_req before exec", 32'(ld_req), 0);
        @(negedge clk);
        chk("R11", "ld_req", 32'(ld_req), 1);
        chk("R11", "ld_addr", 32'(ld_addr), 40);
        drain(10);
        chkreg("R11", 6, 16'd283);
    endtask

    task automatic t_latency();
        int k;
        issue(C_ADD, 3, 1, 2, 16'd0);
        k = 0;
        while (!bus_valid && k < 20) begin @(negedge clk); k++; end
        chk("R6", "add latency", 32'(k), 3);
        chk("R6", "add value", 32'(bus_value), 104);
        drain(5);
        issue(C_MUL, 5, 1, 2, 16'd0);
        k = 0;
        while (!bus_valid && k < 20) begin @(negedge clk); k++; end
        chk("R6", "mul latency", 32'(k), 5);
        chk("R4", "mul tag", 32'(bus_tag), 3);
        drain(10);
    endtask

    task automatic t_arb();
        issue(C_MUL, 5, 1, 2, 16'd0);    // station 3
        @(negedge clk);
        issue(C_ADD, 6, 1, 1, 16'd0);    // station 1, finishes with the multiply
        drain(3);
        chk("R7", "first valid", 32'(bus_valid), 1);
        chk("R7", "first tag", 32'(bus_tag), 1);
        chk("R7", "first value", 32'(bus_value), 76);
        @(negedge clk);
        chk("R7", "second valid", 32'(bus_valid), 1);
        chk("R7", "second tag", 32'(bus_tag), 3);
        chk("R7", "second value", 32'(bus_value), 2508);
        drain(10);
        chkreg("R7", 5, 16'd2508);
        chkreg("R7", 6, 16'd76);
    endtask

    task automatic t_waw();
        issue(C_MUL, 3, 1, 2, 16'd0);
        issue(C_ADD, 3, 1, 1, 16'd0);
        drain(20);
        chkreg("R8", 3, 16'd76);
    endtask

    task automatic t_war();
        issue(C_MUL, 4, 1, 2, 16'd0);    // r4 = 2508 (slow)
        issue(C_DIV, 7, 4, 1, 16'd0);    // reads r4 via tag
        issue(C_ADD, 4, 2, 2, 16'd0);    // later writer of r4 = 132
        drain(30);
        chkreg("R9", 7, 16'd66);
        chkreg("R9", 4, 16'd132);
        chkreg("R5", 1, 16'd38);
    endtask

    task automatic t_struct();
        issue(C_MUL, 5, 1, 2, 16'd0);
        issue(C_ADD, 6, 5, 1, 16'd0);
        issue(C_ADD, 7, 5, 2, 16'd0);
        iss_op = C_MUL; #1;
        chk("R3", "ready mul", 32'(iss_ready), 1);
        iss_op = C_LD; #1;
        chk("R3", "ready ld", 32'(iss_ready), 1);
        iss_op = C_ADD; iss_dst = 3'd1; iss_src1 = 3'd2; iss_src2 = 3'd2;
        iss_valid = 1'b1; #1;
        chk("R3", "ready add full", 32'(iss_ready), 0);
        @(negedge clk);
        @(negedge clk);
        iss_valid = 1'b0;
        drain(30);
        chkreg("R3", 1, 16'd38);
        chkreg("R5", 6, 16'd2546);
        chkreg("R5", 7, 16'd2574);
    endtask

    task automatic t_fwd();
        issue(C_ADD, 3, 1, 2, 16'd0);    // tag 1
        for (int i = 0; i < 20; i++) begin
            if (bus_valid && bus_tag == 3'd1) break;
            @(negedge clk);
        end
        chk("R10", "bus tag", 32'(bus_tag), 1);
        chk("R10", "bus value", 32'(bus_value), 104);
        issue(C_ADD, 4, 3, 1, 16'd0);    // issues on the broadcast edge
        drain(20);
        chkreg("R10", 4, 16'd142);
        chkreg("R10", 3, 16'd104);
    endtask

    initial begin
        rst = 1'b1; iss_valid = 1'b0; iss_op = C_ADD; iss_dst = '0;
        iss_src1 = '0; iss_src2 = '0; iss_imm = '0; rd_idx = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ops();
        t_latency();
        t_arb();
        t_waw();
        t_war();
        t_struct();
        t_fwd();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

endmodule